// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-resolution event timer. A free-running 64-bit count arrives from outside the block. The channel holds a configuration word, a comparator and a period value that software cannot read. When the channel is enabled and the count reaches the comparator, the channel signals an interrupt. In edge mode this is a pulse one cycle long. In level mode it is a sticky status bit. In periodic mode each match also adds the stored period to the comparator, so the channel keeps firing at a fixed interval.

Software programs the channel over a register bus. The bus normally carries 32-bit words with a byte enable for each byte. It also has a double-width option that writes the whole 64-bit comparator in one access. While periodic mode is on, a plain comparator write sets only the hidden period. To move the comparator too, software first sets a one-time arming bit in the configuration. That bit clears itself after the next comparator write. A forced 32-bit mode limits the match and the periodic addition to the low half of the comparator.

Top module: `evtc_chan`

## Requirements
- R1: After reset the configuration reads 0x0000_0030 (only the two capability bits are set), both comparator halves read 0xFFFF_FFFF, the period is zero, `irq_pulse` and `irq_level` are low, and status reads 0.
- R2: The configuration word has these fields: bit 1 selects level (1) or edge (0), bit 2 enables the interrupt, bit 3 selects periodic mode, bit 6 is the arming bit, bit 8 forces 32-bit mode, and bits 13:9 hold a 5-bit route value that is stored and read back. Bits 4 (periodic capable) and 5 (64-bit capable) always read 1, whatever is written. All other bits read 0.
- R3: The register offsets are: configuration 0x00, comparator low half 0x08, comparator high half 0x0C, status 0x10. A 32-bit write changes only the bytes its byte enables select, and only in its own half. A double-width write at 0x08 covers both halves, with enables [3:0] for the low half and [7:4] for the high half.
- R4: With periodic mode off, a comparator write loads the comparator.
- R5: With periodic mode on and the arming bit clear, a comparator write loads only the period. The comparator keeps its value.
- R6: With periodic mode on and the arming bit set, a comparator write loads both the comparator and the period. Any comparator write that takes effect clears the arming bit.
- R7: In 32-bit mode a 32-bit write to the high half at 0x0C is ignored: the comparator, the period and the arming bit are all left unchanged. A double-width write is cut to its low 32 bits, so the high half becomes 0.
- R8: When the channel is enabled in edge mode and the count equals the comparator at a clock edge, `irq_pulse` is high for exactly the following cycle. No pulse occurs when the channel is disabled or in level mode.
- R9: In periodic mode every match adds the period to the comparator on the same edge. In 32-bit mode only the low 32 bits of the count and the comparator are compared, and the addition wraps within the low half while the high half is kept.
- R10: In level mode a match sets `irq_level` and status bit 0. Both stay set until software writes 1 to bit 0 at offset 0x10.
- R11: Writing 0x134 to the configuration enables a 32-bit one-shot edge channel, and the next low-half comparator write programs the compare point at which the channel then fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_i | input | 64 | Free-running main count |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | Double-width write |
| wr_off | input | 5 | Write register offset |
| wr_be | input | 8 | Byte enables |
| wr_data | input | 64 | Write data; 32-bit writes use [31:0] |
| rd_off | input | 5 | Read register offset |
| rd_data | output | 32 | Read data for `rd_off` |
| irq_pulse | output | 1 | Edge-mode interrupt pulse |
| irq_level | output | 1 | Level-mode interrupt status |

## Verification
The match function is driven with four kinds of stimulus. Periodic programming with the arming bit set shows whether the comparator and the period are loaded together. A later periodic write without the arming bit shows whether the period changes on its own while the comparator holds. A one-shot program and the 0x134 sequence confirm that a match fires exactly once and never repeats. A count that jumps near the 32-bit boundary, while the comparator's high half differs from the count's, shows whether the match uses only the low half and whether the periodic addition wraps. Every interrupt pulse is checked against the exact count value at which a match was predicted. Any pulse that arrives early, arrives late or was not predicted is reported as an error.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    localparam int CNT_W      = 64;
    localparam int HALF_W     = CNT_W / 2;
    localparam int LANE_BYTES = HALF_W / 8;
    localparam int BE_W       = CNT_W / 8;
    localparam int OFF_W      = 5;
    localparam int ROUTE_W    = 5;

    localparam logic [OFF_W-1:0] OFF_CFG    = 5'h00;
    localparam logic [OFF_W-1:0] OFF_CMP_LO = 5'h08;
    localparam logic [OFF_W-1:0] OFF_CMP_HI = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_STS    = 5'h10;

    // field positions in the configuration word
    localparam int B_LEVEL  = 1;
    localparam int B_ENABLE = 2;
    localparam int B_PERIOD = 3;
    localparam int B_CAPPER = 4;
    localparam int B_CAPW   = 5;
    localparam int B_ARM    = 6;
    localparam int B_NARROW = 8;
    localparam int B_ROUTE  = 9;

    typedef struct packed {
        logic [ROUTE_W-1:0] route;
        logic               narrow;
        logic               arm;
        logic               periodic;
        logic               enable;
        logic               level;
    } chan_cfg_t;

    typedef struct packed {
        logic cfg;
        logic cmp_lo;
        logic cmp_hi;
        logic cmp_wide;
        logic sts_clr;
    } wr_dec_t;

    function automatic logic [HALF_W-1:0] lane_merge(
        input logic [HALF_W-1:0]     old_v,
        input logic [HALF_W-1:0]     new_v,
        input logic [LANE_BYTES-1:0] be
    );
        logic [HALF_W-1:0] r;
        r = old_v;
        for (int i = 0; i < LANE_BYTES; i++)
            if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] cfg_word(input chan_cfg_t c);
        logic [HALF_W-1:0] w;
        w = '0;
        w[B_LEVEL]  = c.level;
        w[B_ENABLE] = c.enable;
        w[B_PERIOD] = c.periodic;
        w[B_CAPPER] = 1'b1;
        w[B_CAPW]   = 1'b1;
        w[B_ARM]    = c.arm;
        w[B_NARROW] = c.narrow;
        w[B_ROUTE +: ROUTE_W] = c.route;
        return w;
    endfunction

    function automatic chan_cfg_t word_cfg(input logic [HALF_W-1:0] w);
        chan_cfg_t c;
        c.level    = w[B_LEVEL];
        c.enable   = w[B_ENABLE];
        c.periodic = w[B_PERIOD];
        c.arm      = w[B_ARM];
        c.narrow   = w[B_NARROW];
        c.route    = w[B_ROUTE +: ROUTE_W];
        return c;
    endfunction

endpackage

// File: rtl/evtc_cfg.sv
module evtc_cfg
    import evtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [LANE_BYTES-1:0] be,
    input  logic [HALF_W-1:0]     data,
    input  logic                  arm_clr,
    output chan_cfg_t             cfg_o
);
    chan_cfg_t cfg_q;
    chan_cfg_t cfg_n;

    always_comb begin
        cfg_n = word_cfg(lane_merge(cfg_word(cfg_q), data, be));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= cfg_n;
        else if (arm_clr)
            cfg_q.arm <= 1'b0;
    end

    assign cfg_o = cfg_q;

    // R6
    arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_clr && !cfg_wr) |=> !cfg_o.arm);

endmodule

// File: rtl/evtc_cmp.sv
module evtc_cmp
    import evtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_wide,
    input  logic [BE_W-1:0]   be,
    input  logic [CNT_W-1:0]  data,
    input  logic              periodic,
    input  logic              arm,
    input  logic              narrow,
    input  logic              adv,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              arm_clr
);
    logic [CNT_W-1:0]      cmp_q, per_q;
    logic                  do_lo, do_hi, load_cmp, load_per;
    logic [HALF_W-1:0]     hi_src;
    logic [LANE_BYTES-1:0] lo_be, hi_be;
    logic [CNT_W-1:0]      cand_cmp, cand_per, step_val;

    always_comb begin
        do_lo  = wr_lo | wr_wide;
        do_hi  = (wr_hi & ~narrow) | wr_wide;
        lo_be  = be[LANE_BYTES-1:0];
        if (wr_wide) begin
            hi_src = narrow ? '0 : data[CNT_W-1:HALF_W];
            hi_be  = narrow ? '1 : be[BE_W-1:LANE_BYTES];
        end else begin
            hi_src = data[HALF_W-1:0];
            hi_be  = be[LANE_BYTES-1:0];
        end
        cand_cmp[HALF_W-1:0] = do_lo ? lane_merge(cmp_q[HALF_W-1:0], data[HALF_W-1:0], lo_be)
                                     : cmp_q[HALF_W-1:0];
        cand_cmp[CNT_W-1:HALF_W] = do_hi ? lane_merge(cmp_q[CNT_W-1:HALF_W], hi_src, hi_be)
                                         : cmp_q[CNT_W-1:HALF_W];
        cand_per[HALF_W-1:0] = do_lo ? lane_merge(per_q[HALF_W-1:0], data[HALF_W-1:0], lo_be)
                                     : per_q[HALF_W-1:0];
        cand_per[CNT_W-1:HALF_W] = do_hi ? lane_merge(per_q[CNT_W-1:HALF_W], hi_src, hi_be)
                                         : per_q[CNT_W-1:HALF_W];
        load_per = (do_lo | do_hi) & periodic;
        load_cmp = (do_lo | do_hi) & (~periodic | arm);
        arm_clr  = do_lo | do_hi;
        if (narrow)
            step_val = {cmp_q[CNT_W-1:HALF_W], cmp_q[HALF_W-1:0] + per_q[HALF_W-1:0]};
        else
            step_val = cmp_q + per_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            per_q <= '0;
        end else begin
            if (load_per) per_q <= cand_per;
            if (load_cmp)  cmp_q <= cand_cmp;
            else if (adv)  cmp_q <= step_val;
        end
    end

    assign cmp_o = cmp_q;

    // R5
    per_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && periodic && !arm && !adv) |=> $stable(cmp_q));

    // R7
    narrow_hi_ign_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_wide && narrow && !adv) |=> ($stable(cmp_q) && $stable(per_q)));

    // R9
    wide_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !narrow && !wr_lo && !wr_hi && !wr_wide) |=> (cmp_q == $past(cmp_q) + $past(per_q)));

endmodule

// File: rtl/evtc_match.sv
module evtc_match
    import evtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             enable,
    input  logic             level,
    input  logic             periodic,
    input  logic             narrow,
    input  logic             sts_clr,
    output logic             adv,
    output logic             irq_pulse,
    output logic             irq_level
);
    logic hit, hit_q, fire, pulse_q, sts_q;

    always_comb begin
        hit  = narrow ? (cnt[HALF_W-1:0] == cmp[HALF_W-1:0]) : (cnt == cmp);
        fire = enable & hit & ~hit_q;
        adv  = fire & periodic;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q   <= 1'b0;
            pulse_q <= 1'b0;
            sts_q   <= 1'b0;
        end else begin
            hit_q   <= hit;
            pulse_q <= fire & ~level;
            sts_q   <= (fire & level) | (sts_q & ~sts_clr);
        end
    end

    assign irq_pulse = pulse_q;
    assign irq_level = sts_q;

    // R8
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

    // R10
    level_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_level) |-> $past(level && enable));

    // R8
    pulse_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pulse) |-> $past(enable && !level));

endmodule

// File: rtl/evtc_chan.sv
module evtc_chan
    import evtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wr_en,
    input  logic              wr_wide,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [HALF_W-1:0] rd_data,
    output logic              irq_pulse,
    output logic              irq_level
);
    wr_dec_t          dec;
    chan_cfg_t        cfg;
    logic [CNT_W-1:0] cmp;
    logic             arm_clr, adv;

    always_comb begin
        dec.cfg      = wr_en & (wr_off == OFF_CFG);
        dec.cmp_lo   = wr_en & ~wr_wide & (wr_off == OFF_CMP_LO);
        dec.cmp_hi   = wr_en & ~wr_wide & (wr_off == OFF_CMP_HI);
        dec.cmp_wide = wr_en &  wr_wide & (wr_off == OFF_CMP_LO);
        dec.sts_clr  = wr_en & (wr_off == OFF_STS) & wr_be[0] & wr_data[0];
    end

    evtc_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (dec.cfg),
        .be      (wr_be[LANE_BYTES-1:0]),
        .data    (wr_data[HALF_W-1:0]),
        .arm_clr (arm_clr),
        .cfg_o   (cfg)
    );

    evtc_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (dec.cmp_lo),
        .wr_hi    (dec.cmp_hi),
        .wr_wide  (dec.cmp_wide),
        .be       (wr_be),
        .data     (wr_data),
        .periodic (cfg.periodic),
        .arm      (cfg.arm),
        .narrow   (cfg.narrow),
        .adv      (adv),
        .cmp_o    (cmp),
        .arm_clr  (arm_clr)
    );

    evtc_match u_match (
        .clk       (clk),
        .rst       (rst),
        .cnt       (cnt_i),
        .cmp       (cmp),
        .enable    (cfg.enable),
        .level     (cfg.level),
        .periodic  (cfg.periodic),
        .narrow    (cfg.narrow),
        .sts_clr   (dec.sts_clr),
        .adv       (adv),
        .irq_pulse (irq_pulse),
        .irq_level (irq_level)
    );

    always_comb begin
        unique case (rd_off)
            OFF_CFG:    rd_data = cfg_word(cfg);
            OFF_CMP_LO: rd_data = cmp[HALF_W-1:0];
            OFF_CMP_HI: rd_data = cmp[CNT_W-1:HALF_W];
            OFF_STS:    rd_data = {{(HALF_W-1){1'b0}}, irq_level};
            default:    rd_data = '0;
        endcase
    end

    // R2
    caps_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_off == OFF_CFG) |-> (rd_data[5:4] == 2'b11));

endmodule

// File: tb/tb_evtc_chan.sv
module tb_evtc_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cnt = '0;
    logic        cnt_ld = 1'b0;
    logic [63:0] cnt_ld_val = '0;
    logic        wr_en = 1'b0, wr_wide = 1'b0;
    logic [4:0]  wr_off = '0, rd_off = '0;
    logic [7:0]  wr_be = '0;
    logic [63:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_pulse, irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] exp_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cnt <= cnt_ld ? cnt_ld_val : cnt + 64'd1;

    evtc_chan dut (
        .clk(clk), .rst(rst), .cnt_i(cnt),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_off(wr_off), .wr_be(wr_be), .wr_data(wr_data),
        .rd_off(rd_off), .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_level(irq_level)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] off, input logic [63:0] d, input logic [7:0] be, input logic wide);
        @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_data = d; wr_be = be; wr_wide = wide;
        @(negedge clk);
        wr_en = 1'b0; wr_wide = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] off, input logic [31:0] exp);
        rd_off = off;
        #1;
        chk(req, {32'd0, rd_data}, {32'd0, exp});
    endtask

    task automatic wait_cnt(input logic [63:0] v);
        while (cnt < v) @(negedge clk);
    endtask

    task automatic load_cnt(input logic [63:0] v);
        @(negedge clk);
        cnt_ld = 1'b1; cnt_ld_val = v;
        @(negedge clk);
        cnt_ld = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: scoreboard of predicted match counts for edge pulses (R8)
    always @(negedge clk) begin
        if (!rst) begin
            if (irq_pulse) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R8 unexpected pulse actual=%h expected=none", cnt - 64'd1);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    if (e !== cnt - 64'd1) begin
                        errors++;
                        $display("FAIL R8 pulse at actual=%h expected=%h", cnt - 64'd1, e);
                    end
                end
            end else if (exp_q.size() != 0 && exp_q[0] == cnt - 64'd1) begin
                checks++;
                errors++;
                $display("FAIL R8 missing pulse actual=none expected=%h", exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk("R1 cfg", 5'h00, 32'h30);
        rd_chk("R1 cmp lo", 5'h08, 32'hFFFF_FFFF);
        rd_chk("R1 cmp hi", 5'h0C, 32'hFFFF_FFFF);
        rd_chk("R1 status", 5'h10, 32'h0);
        chk("R1 irq", {62'd0, irq_pulse, irq_level}, 64'd0);

        // R2 capability bits read-only, route stored
        wr(5'h00, 64'h0, 8'h0F, 1'b0);
        rd_chk("R2 caps kept", 5'h00, 32'h30);
        wr(5'h00, 64'hFFFF_FEB1, 8'h0F, 1'b0);
        rd_chk("R2 fields", 5'h00, 32'h3E30);
        wr(5'h00, 64'h0, 8'h0F, 1'b0);

        // R6 periodic with arm: wide write loads comparator and period
        wr(5'h00, 64'h4C, 8'h0F, 1'b0);
        wr(5'h08, 64'd100, 8'hFF, 1'b1);
        rd_chk("R6 arm cleared", 5'h00, 32'h3C);
        rd_chk("R6 cmp loaded", 5'h08, 32'd100);
        rd_chk("R3 wide hi", 5'h0C, 32'd0);
        exp_q.push_back(64'd100);
        exp_q.push_back(64'd200);
        exp_q.push_back(64'd300);
        wait_cnt(64'd310);
        rd_chk("R9 advance", 5'h08, 32'd400);

        // R5 periodic without arm: period only
        wr(5'h00, 64'h0C, 8'h0F, 1'b0);
        wr(5'h08, 64'd50, 8'h0F, 1'b0);
        rd_chk("R5 cmp held", 5'h08, 32'd400);
        exp_q.push_back(64'd400);
        exp_q.push_back(64'd450);
        exp_q.push_back(64'd500);
        wait_cnt(64'd505);
        wr(5'h00, 64'h0, 8'h0F, 1'b0);
        rd_chk("R9 after stop", 5'h08, 32'd550);

        // R4 one-shot with partial byte enables (R3)
        wr(5'h00, 64'h04, 8'h0F, 1'b0);
        wr(5'h08, 64'hAAAA_0258, 8'h03, 1'b0);
        rd_chk("R3 byte lanes", 5'h08, 32'd600);
        exp_q.push_back(64'd600);
        wait_cnt(64'd620);
        rd_chk("R4 one-shot holds", 5'h08, 32'd600);

        // R11 0x134 sequence, R7 narrow high write ignored
        wr(5'h00, 64'h134, 8'h0F, 1'b0);
        rd_chk("R11 cfg", 5'h00, 32'h134);
        wr(5'h0C, 64'hDEAD, 8'h0F, 1'b0);
        rd_chk("R7 hi ignored", 5'h0C, 32'd0);
        wr(5'h08, 64'd700, 8'h0F, 1'b0);
        rd_chk("R11 cmp", 5'h08, 32'd700);
        exp_q.push_back(64'd700);
        wait_cnt(64'd710);

        // R7 wide write truncated in 32-bit mode
        wr(5'h08, 64'h0000_0005_0000_02EE, 8'hFF, 1'b1);
        rd_chk("R7 truncated hi", 5'h0C, 32'd0);
        rd_chk("R7 truncated lo", 5'h08, 32'd750);
        exp_q.push_back(64'd750);
        wait_cnt(64'd760);

        // R10 level mode
        wr(5'h00, 64'h06, 8'h0F, 1'b0);
        wr(5'h08, 64'd800, 8'h0F, 1'b0);
        wait_cnt(64'd798);
        chk("R10 before match", {63'd0, irq_level}, 64'd0);
        wait_cnt(64'd810);
        chk("R10 set", {63'd0, irq_level}, 64'd1);
        rd_chk("R10 status", 5'h10, 32'd1);
        wait_cnt(64'd830);
        chk("R10 sticky", {63'd0, irq_level}, 64'd1);
        wr(5'h10, 64'd1, 8'h0F, 1'b0);
        chk("R10 cleared", {63'd0, irq_level}, 64'd0);
        wr(5'h00, 64'h0, 8'h0F, 1'b0);

        // R9 32-bit periodic wrap
        load_cnt(64'hFFFF_FF00);
        wr(5'h00, 64'h14C, 8'h0F, 1'b0);
        wr(5'h08, 64'hFFFF_FF80, 8'h0F, 1'b0);
        wr(5'h08, 64'h100, 8'h0F, 1'b0);
        rd_chk("R5 narrow per only", 5'h08, 32'hFFFF_FF80);
        exp_q.push_back(64'h0000_0000_FFFF_FF80);
        exp_q.push_back(64'h0000_0001_0000_0080);
        wait_cnt(64'h0000_0001_0000_0090);
        rd_chk("R9 wrap lo", 5'h08, 32'h180);
        rd_chk("R9 hi kept", 5'h0C, 32'd0);

        repeat (4) @(negedge clk);
        chk("R8 all pulses seen", exp_q.size(), 64'd0);
        finish_run();
    end
endmodule